// File: doc/BRIEF.md
# Divide-by-Zero and Operand-Error Responder

This block sits beside a floating-point function unit and reacts when that unit reports that an operation hit a zero divisor or had no valid result. For each such event it works out the default 80-bit extended-precision answer and updates a 32-bit status word. The status word holds four condition flags, an exception status byte and a sticky accrued-exception byte.

Each fault class has its own trap enable. When the trap is off, the block delivers the default answer with a one-cycle valid pulse. When the trap is on, the block updates the same flags but withholds the answer. Instead it raises a store-inhibit flag, which tells the register file to leave the destination untouched.

There are two divide-by-zero flavours. The general one produces an infinity that carries the sign of the source operand. The logarithm-style one always produces negative infinity. An invalid operation produces the default quiet NaN.

Top module: `fpx_fault_resp`

## Requirements
- R1: After reset, `status` is zero, `res_valid` is 0 and `store_inh` is 0.
- R2: An accepted event with its trap disabled gives `res_valid` high for exactly the one cycle after the strobe edge. `res_valid` is low in every other cycle.
- R3: Event kind 0 (general divide-by-zero) with its trap disabled returns +infinity `80'h7FFF_0000000000000000` when `src_neg` is 0, and -infinity `80'hFFFF_0000000000000000` when `src_neg` is 1.
- R4: Event kind 1 (log divide-by-zero) always sets the negative flag (status bit 27). With its trap disabled it always returns -infinity, whatever `src_neg` is.
- R5: A divide-by-zero event (kind 0 or 1) overwrites the condition nibble (bits 27:24) and the exception byte (bits 15:8). Afterwards:
  - the infinity flag (bit 24+1 = 25) is set;
  - bit 27 is set only for a negative effective sign;
  - the only exception bit set is bit 10 (divide-by-zero);
  - the accrued divide-by-zero bit 4 is ORed in.
- R6: Event kind 2 (operand error) ORs in the NaN flag (bit 24), the operand-error exception bit 13 and the accrued invalid bit 7. All other bits are kept. With its trap disabled it returns `80'h7FFF_FFFFFFFFFFFFFFFF`.
- R7: With the matching trap enabled (`trap_en_dz` for kinds 0 and 1, `trap_en_operr` for kind 2), the status update is the same as with the trap disabled. `res_valid` stays low and `store_inh` is 1 from the cycle after the strobe.
- R8: `store_inh` keeps its value until the next accepted event, which sets it to that event's trap state.
- R9: Accrued bits 7:0 only ever gain set bits, except through `stat_clr`, which clears them. When `stat_clr` and an event arrive in the same cycle, the event's accrued bit survives the clear.
- R10: A cycle without `evt_valid`, or with event kind 3, changes neither `status` (apart from a `stat_clr`), nor `store_inh`, and produces no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Fault event strobe |
| evt_kind | input | 2 | 0 general divide-by-zero, 1 log divide-by-zero, 2 operand error, 3 reserved |
| src_neg | input | 1 | Sign of the source operand (1 = negative) |
| trap_en_dz | input | 1 | Divide-by-zero trap enable |
| trap_en_operr | input | 1 | Operand-error trap enable |
| stat_clr | input | 1 | Clears the accrued byte |
| res_valid | output | 1 | One-cycle pulse when `res_value` holds a default result |
| res_value | output | 80 | Default extended-precision result |
| status | output | 32 | Condition nibble [27:24], exception byte [15:8], accrued byte [7:0] |
| store_inh | output | 1 | Destination write must be suppressed |

## Verification
The hardest case to reach is a divide-by-zero event arriving on top of earlier history. The event must erase an operand-error exception bit and a previous negative flag, yet leave the sticky accrued bits in place. A single event from reset never shows this.

The bench therefore walks every combination of strobe, kind, sign, both trap enables and the accrued clear in one continuous sequence. Each step inherits the status and store-inhibit state left by the one before. A bench-side model of the status word tracks that state, so the erase, sticky and same-cycle-clear cases all occur many times.

// File: rtl/fpx_fault_pkg.sv
package fpx_fault_pkg;

    localparam int EXP_W  = 15;
    localparam int MANT_W = 64;
    localparam int VAL_W  = 1 + EXP_W + MANT_W;
    localparam int STAT_W = 32;

    typedef enum logic [1:0] {
        KIND_DZ    = 2'd0,
        KIND_DZLOG = 2'd1,
        KIND_OPERR = 2'd2,
        KIND_RSVD  = 2'd3
    } fault_kind_e;

    // condition nibble positions (within the nibble)
    localparam int CC_NEG = 3;
    localparam int CC_INF = 1;
    localparam int CC_NAN = 0;
    // exception byte positions
    localparam int EX_OPERR = 5;
    localparam int EX_DZ    = 2;
    // accrued byte positions
    localparam int AC_IOP = 7;
    localparam int AC_DZ  = 4;

    typedef struct packed {
        logic              valid;
        logic [VAL_W-1:0]  value;
        logic [STAT_W-1:0] status;
        logic              inhibit;
    } resp_state_t;

endpackage

// File: rtl/fpx_fault_value.sv
module fpx_fault_value
    import fpx_fault_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int M_W = MANT_W
) (
    input  fault_kind_e        kind,
    input  logic               neg_eff,
    output logic [E_W+M_W:0]   value
);
    localparam logic [E_W-1:0] EXP_MAX = {E_W{1'b1}};

    always_comb begin
        unique case (kind)
            KIND_DZ, KIND_DZLOG: value = {neg_eff, EXP_MAX, {M_W{1'b0}}};
            KIND_OPERR:          value = {1'b0, EXP_MAX, {M_W{1'b1}}};
            default:             value = '0;
        endcase
    end
endmodule

// File: rtl/fpx_fault_flags.sv
module fpx_fault_flags
    import fpx_fault_pkg::*;
(
    input  logic [STAT_W-1:0] status_q,
    input  logic              fire,
    input  fault_kind_e       kind,
    input  logic              neg_eff,
    input  logic              clr,
    output logic [STAT_W-1:0] status_d
);
    logic [3:0] cc_d;
    logic [7:0] exc_d;
    logic [7:0] acc_d;

    always_comb begin
        cc_d  = status_q[27:24];
        exc_d = status_q[15:8];
        acc_d = clr ? 8'h00 : status_q[7:0];
        if (fire) begin
            unique case (kind)
                KIND_DZ, KIND_DZLOG: begin
                    cc_d           = '0;
                    cc_d[CC_INF]   = 1'b1;
                    cc_d[CC_NEG]   = neg_eff;
                    exc_d          = '0;
                    exc_d[EX_DZ]   = 1'b1;
                    acc_d[AC_DZ]   = 1'b1;
                end
                KIND_OPERR: begin
                    cc_d[CC_NAN]    = 1'b1;
                    exc_d[EX_OPERR] = 1'b1;
                    acc_d[AC_IOP]   = 1'b1;
                end
                default: ;
            endcase
        end
        status_d = {4'h0, cc_d, 8'h00, exc_d, acc_d};
    end
endmodule

// File: rtl/fpx_fault_resp.sv
module fpx_fault_resp
    import fpx_fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic              src_neg,
    input  logic              trap_en_dz,
    input  logic              trap_en_operr,
    input  logic              stat_clr,
    output logic              res_valid,
    output logic [VAL_W-1:0]  res_value,
    output logic [STAT_W-1:0] status,
    output logic              store_inh
);
    resp_state_t r_d, r_q;

    fault_kind_e       kind;
    logic              fire, is_dz, trap, neg_eff;
    logic [VAL_W-1:0]  dflt_val;
    logic [STAT_W-1:0] status_nx;

    assign kind    = fault_kind_e'(evt_kind);
    assign is_dz   = (kind == KIND_DZ) || (kind == KIND_DZLOG);
    assign fire    = evt_valid && (kind != KIND_RSVD);
    assign neg_eff = (kind == KIND_DZLOG) || src_neg;
    assign trap    = is_dz ? trap_en_dz : trap_en_operr;

    fpx_fault_value #(.E_W(EXP_W), .M_W(MANT_W)) u_value (
        .kind    (kind),
        .neg_eff (neg_eff),
        .value   (dflt_val)
    );

    fpx_fault_flags u_flags (
        .status_q (r_q.status),
        .fire     (fire),
        .kind     (kind),
        .neg_eff  (neg_eff),
        .clr      (stat_clr),
        .status_d (status_nx)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = fire && !trap;
        r_d.status  = status_nx;
        if (fire) begin
            r_d.inhibit = trap;
            if (!trap) r_d.value = dflt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_valid = r_q.valid;
    assign res_value = r_q.value;
    assign status    = r_q.status;
    assign store_inh = r_q.inhibit;

    p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(evt_valid));

    p_inhibit_blocks_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        store_inh |-> !res_valid);

    p_accrued_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((status[7:0] & $past(status[7:0])) == $past(status[7:0])));

    p_log_sets_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd1) |=> status[27]);

    p_inhibit_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid || evt_kind == 2'd3) |=> $stable(store_inh));
endmodule

// File: tb/tb_fpx_fault_resp.sv
module tb_fpx_fault_resp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic        src_neg = 1'b0, trap_en_dz = 1'b0, trap_en_operr = 1'b0, stat_clr = 1'b0;
    logic        res_valid, store_inh;
    logic [79:0] res_value;
    logic [31:0] status;

    int checks = 0, fails = 0;
    logic [31:0] m_stat = '0;
    logic        m_inh = 1'b0;

    always #2 clk = ~clk;

    fpx_fault_resp dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .src_neg(src_neg), .trap_en_dz(trap_en_dz), .trap_en_operr(trap_en_operr),
        .stat_clr(stat_clr), .res_valid(res_valid), .res_value(res_value),
        .status(status), .store_inh(store_inh)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic ev, input logic [1:0] k, input logic s,
                        input logic edz, input logic eop, input logic clr);
        logic        fire, trap, neg, x_valid;
        logic [79:0] x_val;
        // idle cycle before: no pulse (R2)
        chk("R2 idle", {79'd0, res_valid}, 80'd0);
        chk("R10 idle inhibit", {79'd0, store_inh}, {79'd0, m_inh});
        evt_valid = ev; evt_kind = k; src_neg = s;
        trap_en_dz = edz; trap_en_operr = eop; stat_clr = clr;
        fire = ev && (k != 2'd3);
        trap = (k == 2'd2) ? eop : edz;
        neg  = (k == 2'd1) || s;
        x_valid = 1'b0; x_val = '0;
        if (clr) m_stat[7:0] = 8'h00;          // R9
        if (fire) begin
            if (k != 2'd2) begin               // R5
                m_stat[27:24] = {neg, 2'b01, 1'b0};
                m_stat[15:8]  = 8'h04;
                m_stat[4]     = 1'b1;
                x_val = {neg, 15'h7FFF, 64'd0}; // R3 R4
            end else begin                     // R6
                m_stat[24] = 1'b1;
                m_stat[13] = 1'b1;
                m_stat[7]  = 1'b1;
                x_val = {16'h7FFF, {64{1'b1}}};
            end
            m_inh   = trap;                     // R7 R8
            x_valid = !trap;
        end
        @(negedge clk);
        chk("R2 R7 valid", {79'd0, res_valid}, {79'd0, x_valid});
        if (x_valid) chk("R3 R4 R6 value", res_value, x_val);
        chk("R5 R6 R9 R10 status", {48'd0, status}, {48'd0, m_stat});
        chk("R7 R8 inhibit", {79'd0, store_inh}, {79'd0, m_inh});
        evt_valid = 1'b0; stat_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", {48'd0, status}, 80'd0);
        chk("R1 valid", {79'd0, res_valid}, 80'd0);
        chk("R1 inhibit", {79'd0, store_inh}, 80'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int pass = 0; pass < 2; pass++)
            for (int c = 0; c < 128; c++)
                step(c[0], c[2:1] ^ pass[1:0], c[3], c[4], c[5], c[6] & c[0]);
        // stat_clr alone, after accrued bits are set (R9 R10)
        step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule